// File: doc/BRIEF.md
# Dual-Point Pulse-Width Modulator

This block generates one pulse-width modulated output from a single input clock. A two-stage prescaler, a binary shift followed by a linear divide, sets the length of one time quantum. An 8-bit phase counter counts quanta and wraps at a programmable limit, and each wrap marks a period boundary. Within each period the output is active from a programmable start point to a programmable stop point. When the stop point comes before the start point, the active window wraps across the boundary. When the two points are equal, the output is active for the whole period.

All settings arrive as plain, register-style input fields. There is no data stream, so there is no valid/ready handshake. Two controls enable the output: a counter enable, which runs the counters and holds them in reset when clear, and a pin enable, which gates only the pad. Polarity inversion and open-drain pad mode act at once on the output. Timing fields (divider, period limit and both points) pass through a shadow stage. With synchronised update they load at a period boundary. With synchronised update disabled they load on the next clock. While the counter is disabled they load continuously, so values written during that time apply as soon as the counter is enabled again.

Top module: `pwm_dualpoint`

## Requirements
- R1: One quantum lasts (cfg_div_lin + 1) << cfg_div_exp input clocks.
- R2: One period lasts (cfg_period + 1) quanta. When cfg_rise < cfg_fall, the output is active for quanta cfg_rise to cfg_fall-1 of each period, so the active time is (cfg_fall - cfg_rise) quanta.
- R3: When cfg_rise > cfg_fall, the active window wraps across the boundary, so the active time is (cfg_period + 1 - cfg_rise + cfg_fall) quanta.
- R4: When cfg_rise equals cfg_fall, the output stays at the active level for the whole period.
- R5: While cfg_cnt_en is 0, the prescaler and phase counter are held at zero and the output is at the inactive level. The output reaches the inactive level in the same cycle cfg_cnt_en drops. Timing fields written while the counter is off take effect as soon as it is enabled.
- R6: While cfg_pin_en is 0, the output is at the inactive level whatever the counter state.
- R7: Active level is 1 and inactive level is 0 when cfg_invert is 0. Both are swapped when cfg_invert is 1, and the swap reaches the output in the same cycle.
- R8: With cfg_sync_off = 0, a change to the timing fields during a period leaves that period unchanged and applies from the next period on.
- R9: With cfg_sync_off = 1, a change to the timing fields applies from the next clock, within the running period.
- R10: With cfg_open_drain = 1, pwm_o is always 0 and pwm_oe is 1 only for a low level. With cfg_open_drain = 0, pwm_oe is 1 and pwm_o carries the level.
- R11: After reset with all fields 0, pwm_o is 0 and pwm_oe is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; the quantum is counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div_lin | input | 8 | Linear prescaler field; the divide is value + 1 |
| cfg_div_exp | input | 4 | Shift prescaler field; multiplies by 2^value |
| cfg_period | input | 8 | Last phase-count value of a period |
| cfg_rise | input | 8 | Phase count at which the output turns active |
| cfg_fall | input | 8 | Phase count at which the output turns inactive |
| cfg_pin_en | input | 1 | Pad enable; 0 forces the inactive level |
| cfg_cnt_en | input | 1 | Counter enable; 0 holds the counters in reset |
| cfg_invert | input | 1 | Polarity swap, applied at once |
| cfg_open_drain | input | 1 | 1 selects open-drain pad behaviour |
| cfg_sync_off | input | 1 | 1 loads timing fields at once instead of at the boundary |
| pwm_o | output | 1 | Pad data |
| pwm_oe | output | 1 | Pad output enable |

## Verification
A corrupted prescaler or phase count shows up as active and inactive run lengths on pwm_o that differ from the computed quantum multiples. The mismatch appears within one period of the fault. A shadow stage that loads at the wrong moment shows in the period during which a field is changed. With synchronised update on, that period must keep its old active length. With it off, the same period must take the new one. Both cases are visible within a single period. A gating or polarity error in the pad stage shows in the very cycle the control changes, because enable, inversion and pad-mode changes have no register between input and pin.

// File: rtl/pwmdp_pkg.sv
package pwmdp_pkg;
  localparam int LIN_W = 8;
  localparam int EXP_W = 4;
  localparam int PH_W  = 8;
  localparam int QW    = LIN_W + 1 + (2 ** EXP_W) - 1;

  typedef struct packed {
    logic [LIN_W-1:0] div_lin;
    logic [EXP_W-1:0] div_exp;
    logic [PH_W-1:0]  period;
    logic [PH_W-1:0]  rise;
    logic [PH_W-1:0]  fall;
  } shape_t;
endpackage

// File: rtl/pwmdp_shadow.sv
module pwmdp_shadow
  import pwmdp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cnt_en,
  input  logic   sync_off,
  input  logic   boundary,
  input  shape_t req,
  output shape_t act
);
  logic load;
  assign load = !cnt_en || sync_off || boundary;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    act <= '0;
    else if (load) act <= req;
  end

  // R8: outside a boundary, with sync on and counter running, nothing moves
  a_r8_hold_between_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !sync_off && !boundary) |=> $stable(act));
endmodule

// File: rtl/pwmdp_prescale.sv
module pwmdp_prescale
  import pwmdp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [LIN_W-1:0] div_lin,
  input  logic [EXP_W-1:0] div_exp,
  output logic             tick
);
  logic [QW-1:0] q_cnt;
  logic [QW-1:0] q_base;
  logic [QW-1:0] q_last;

  assign q_base = QW'(div_lin) + QW'(1);
  assign q_last = (q_base << div_exp) - QW'(1);
  assign tick   = cnt_en && (q_cnt >= q_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_cnt <= '0;
    else if (!cnt_en) q_cnt <= '0;
    else if (tick)    q_cnt <= '0;
    else              q_cnt <= q_cnt + QW'(1);
  end

  // R5: a disabled counter leaves the prescaler at zero
  a_r5_prescale_held: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> (q_cnt == '0));
endmodule

// File: rtl/pwmdp_phase.sv
module pwmdp_phase
  import pwmdp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cnt_en,
  input  logic            tick,
  input  logic [PH_W-1:0] period,
  input  logic [PH_W-1:0] rise,
  input  logic [PH_W-1:0] fall,
  output logic [PH_W-1:0] phase,
  output logic            boundary,
  output logic            active
);
  logic at_end;
  // >= keeps the count bounded when a shorter period loads mid-run
  assign at_end   = (phase >= period);
  assign boundary = tick && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase <= '0;
    else if (!cnt_en)  phase <= '0;
    else if (boundary) phase <= '0;
    else if (tick)     phase <= phase + PH_W'(1);
  end

  always_comb begin
    if (rise == fall)     active = 1'b1;
    else if (rise < fall) active = (phase >= rise) && (phase < fall);
    else                  active = (phase >= rise) || (phase < fall);
  end

  // R2: the quantum that ends a period is followed by phase zero
  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && tick && at_end) |=> (phase == '0));
endmodule

// File: rtl/pwmdp_pad.sv
module pwmdp_pad (
  input  logic active,
  input  logic cnt_en,
  input  logic pin_en,
  input  logic invert,
  input  logic open_drain,
  output logic pad_o,
  output logic pad_oe
);
  logic level;
  assign level  = (cnt_en && pin_en && active) ^ invert;
  assign pad_o  = open_drain ? 1'b0 : level;
  assign pad_oe = open_drain ? !level : 1'b1;
endmodule

// File: rtl/pwm_dualpoint.sv
module pwm_dualpoint
  import pwmdp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LIN_W-1:0] cfg_div_lin,
  input  logic [EXP_W-1:0] cfg_div_exp,
  input  logic [PH_W-1:0]  cfg_period,
  input  logic [PH_W-1:0]  cfg_rise,
  input  logic [PH_W-1:0]  cfg_fall,
  input  logic             cfg_pin_en,
  input  logic             cfg_cnt_en,
  input  logic             cfg_invert,
  input  logic             cfg_open_drain,
  input  logic             cfg_sync_off,
  output logic             pwm_o,
  output logic             pwm_oe
);
  shape_t          req_shape;
  shape_t          act_shape;
  logic            tick;
  logic            boundary;
  logic            active;
  logic [PH_W-1:0] phase;

  assign req_shape = '{div_lin: cfg_div_lin, div_exp: cfg_div_exp,
                       period: cfg_period, rise: cfg_rise, fall: cfg_fall};

  pwmdp_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .cnt_en(cfg_cnt_en), .sync_off(cfg_sync_off),
    .boundary(boundary), .req(req_shape), .act(act_shape));

  pwmdp_prescale u_prescale (
    .clk(clk), .rst_n(rst_n), .cnt_en(cfg_cnt_en),
    .div_lin(act_shape.div_lin), .div_exp(act_shape.div_exp), .tick(tick));

  pwmdp_phase u_phase (
    .clk(clk), .rst_n(rst_n), .cnt_en(cfg_cnt_en), .tick(tick),
    .period(act_shape.period), .rise(act_shape.rise), .fall(act_shape.fall),
    .phase(phase), .boundary(boundary), .active(active));

  pwmdp_pad u_pad (
    .active(active), .cnt_en(cfg_cnt_en), .pin_en(cfg_pin_en),
    .invert(cfg_invert), .open_drain(cfg_open_drain),
    .pad_o(pwm_o), .pad_oe(pwm_oe));

  // R4: equal points keep a running, enabled, push-pull output active
  a_r4_equal_points_full: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cnt_en && cfg_pin_en && !cfg_invert && !cfg_open_drain &&
     act_shape.rise == act_shape.fall) |-> pwm_o);

  // R6: pad disabled in push-pull mode shows the inactive level
  a_r6_pin_off_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_pin_en && !cfg_open_drain) |-> (pwm_o == cfg_invert && pwm_oe));

  // R5: counter held at zero while disabled
  a_r5_phase_held: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_cnt_en |=> (phase == '0));

  // R10: open-drain pad never drives high
  a_r10_od_low_only: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_open_drain |-> !pwm_o);
endmodule

// File: tb/pwm_dualpoint_bench.sv
module pwm_dualpoint_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_div_lin = '0;
  logic [3:0] cfg_div_exp = '0;
  logic [7:0] cfg_period = '0;
  logic [7:0] cfg_rise = '0;
  logic [7:0] cfg_fall = '0;
  logic cfg_pin_en = 0, cfg_cnt_en = 0, cfg_invert = 0;
  logic cfg_open_drain = 0, cfg_sync_off = 0;
  logic pwm_o, pwm_oe;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm_dualpoint u_pwm_dualpoint (
    .clk(clk), .rst_n(rst_n), .cfg_div_lin(cfg_div_lin), .cfg_div_exp(cfg_div_exp),
    .cfg_period(cfg_period), .cfg_rise(cfg_rise), .cfg_fall(cfg_fall),
    .cfg_pin_en(cfg_pin_en), .cfg_cnt_en(cfg_cnt_en), .cfg_invert(cfg_invert),
    .cfg_open_drain(cfg_open_drain), .cfg_sync_off(cfg_sync_off),
    .pwm_o(pwm_o), .pwm_oe(pwm_oe));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: sample between edges
  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic setup(input int lin, input int ex, input int per, input int ri, input int fa);
    cfg_cnt_en = 0;
    step();
    cfg_div_lin = 8'(lin); cfg_div_exp = 4'(ex);
    cfg_period = 8'(per); cfg_rise = 8'(ri); cfg_fall = 8'(fa);
    step();
    cfg_cnt_en = 1;
  endtask

  // waits for a 0->1 edge of pwm_o, returns the high and following low run in clocks
  task automatic measure(output int hi, output int lo);
    logic prev;
    int guard;
    hi = 0; lo = 0; guard = 0;
    step();
    prev = pwm_o;
    while (!(prev == 1'b0 && pwm_o == 1'b1) && guard < 20000) begin
      prev = pwm_o; step(); guard++;
    end
    while (pwm_o == 1'b1 && guard < 20000) begin hi++; step(); guard++; end
    while (pwm_o == 1'b0 && guard < 20000) begin lo++; step(); guard++; end
  endtask

  task automatic run_len_const(input logic val, input int n, output int mism);
    mism = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (pwm_o !== val) mism++;
    end
  endtask

  task automatic t_reset();
    chk(pwm_o == 1'b0, "R11 reset pwm_o", int'(pwm_o), 0);
    chk(pwm_oe == 1'b1, "R11 reset pwm_oe", int'(pwm_oe), 1);
  endtask

  task automatic t_basic();
    int hi, lo;
    cfg_pin_en = 1;
    setup(1, 1, 9, 2, 5);            // Q = 4
    measure(hi, lo);
    chk(hi == 12, "R1 R2 high Q=4", hi, 12);
    chk(lo == 28, "R1 R2 low Q=4", lo, 28);
    setup(2, 2, 3, 0, 1);            // Q = 12
    measure(hi, lo);
    chk(hi == 12, "R1 high Q=12", hi, 12);
    chk(lo == 36, "R1 low Q=12", lo, 36);
  endtask

  task automatic t_wrap();
    int hi, lo;
    setup(1, 0, 7, 6, 2);            // Q = 2, active quanta 6,7,0,1
    measure(hi, lo);
    chk(hi == 8, "R3 wrapped high", hi, 8);
    chk(lo == 8, "R3 wrapped low", lo, 8);
  endtask

  task automatic t_equal_and_controls();
    int m;
    setup(0, 1, 3, 1, 1);
    step(); step();
    run_len_const(1'b1, 60, m);
    chk(m == 0, "R4 equal points always active", m, 0);
    cfg_invert = 1; #1;
    chk(pwm_o == 1'b0, "R7 invert immediate", int'(pwm_o), 0);
    cfg_cnt_en = 0; #1;
    chk(pwm_o == 1'b1, "R5 R7 disabled inactive inverted", int'(pwm_o), 1);
    cfg_invert = 0; #1;
    chk(pwm_o == 1'b0, "R5 disabled inactive", int'(pwm_o), 0);
    cfg_cnt_en = 1;
    step(); step();
    cfg_pin_en = 0; #1;
    chk(pwm_o == 1'b0, "R6 pin off immediate", int'(pwm_o), 0);
    run_len_const(1'b0, 40, m);
    chk(m == 0, "R6 pin off held", m, 0);
    cfg_pin_en = 1;
    cfg_open_drain = 1; #1;
    chk(pwm_o == 1'b0 && pwm_oe == 1'b0, "R10 od high released", int'(pwm_oe), 0);
    cfg_pin_en = 0; #1;
    chk(pwm_o == 1'b0 && pwm_oe == 1'b1, "R10 od low driven", int'(pwm_oe), 1);
    cfg_open_drain = 0; cfg_pin_en = 1;
  endtask

  task automatic t_disable_mid();
    int hi, lo, m;
    setup(3, 0, 9, 0, 5);            // Q = 4
    measure(hi, lo);
    // pwm_o has just gone high; drop the counter now
    step();
    cfg_cnt_en = 0; #1;
    chk(pwm_o == 1'b0, "R5 disable mid-period", int'(pwm_o), 0);
    cfg_period = 3; cfg_rise = 1; cfg_fall = 2; cfg_div_lin = 1; cfg_div_exp = 0;
    run_len_const(1'b0, 30, m);
    chk(m == 0, "R5 held while off", m, 0);
    cfg_cnt_en = 1;
    measure(hi, lo);                 // Q = 2
    chk(hi == 2 && lo == 6, "R5 fields written while off apply", hi * 100 + lo, 206);
  endtask

  task automatic t_sync(input bit off);
    int hi, lo, guard;
    logic prev;
    cfg_sync_off = off;
    setup(0, 0, 99, 0, 50);          // Q = 1
    guard = 0;
    step(); prev = pwm_o;
    while (!(prev == 1'b0 && pwm_o == 1'b1) && guard < 5000) begin
      prev = pwm_o; step(); guard++;
    end
    hi = 1;
    for (int i = 0; i < 4; i++) begin step(); if (pwm_o) hi++; end
    cfg_fall = 80;
    step();
    while (pwm_o == 1'b1 && guard < 5000) begin hi++; step(); guard++; end
    if (!off) begin
      chk(hi == 50, "R8 running period keeps old fall", hi, 50);
      measure(hi, lo);
      chk(hi == 80, "R8 next period uses new fall", hi, 80);
    end else begin
      chk(hi == 80, "R9 running period takes new fall", hi, 80);
    end
    cfg_sync_off = 0;
  endtask

  initial begin
    repeat (3) step();
    t_reset();
    rst_n = 1;
    step();
    t_reset();
    t_basic();
    t_wrap();
    t_equal_and_controls();
    t_disable_mid();
    t_sync(1'b0);
    t_sync(1'b1);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule